// File: doc/BRIEF.md
# DMA Channel Request and Event Register Bank

This block keeps the per-channel control and status bits of a 32-channel DMA controller and picks which channel is served next. Software reaches it through a simple register bus with byte-wide command registers: it writes a channel number to one command byte, and the block sets or clears that single channel's bit. No read-modify-write of a shared word is needed, so separate software threads can drive different channels without locking.

Four bit vectors are held: request enable, error-interrupt enable, interrupt pending and error pending. The engine pulses per-channel interrupt and error events in through hardware inputs. A selector looks at channels whose peripheral request is high and whose request enable is set, and grants one each cycle. A control bit picks fixed priority or round robin. A halt bit, or a halt-on-error bit combined with any pending error, stops new grants. Two interrupt lines leave the block.

Driver sequencing is expected to enable a channel's error reporting before its request, and to drop the request before dropping error reporting; the block imposes no ordering of its own.

Top module: `chan_ctrl_bank`

## Requirements
- R1: A write to byte offset 0x1B sets the request-enable bit of the channel given by the low 5 bits of wdata_i, and a write to 0x1A clears it; the request-enable word reads at 0x0C with bit n for channel n. The upper 3 bits of the command byte are ignored.
- R2: A write to 0x19 sets the channel's error-interrupt-enable bit and a write to 0x18 clears it; the word reads at 0x14.
- R3: A high int_evt_i[n] sets interrupt-pending bit n; a write of n to 0x1F clears it; the pending word reads at 0x24 and reading it changes nothing.
- R4: A high err_evt_i[n] sets error-pending bit n; a write of n to 0x1E clears it; the word reads at 0x2C.
- R5: When a hardware event and a software clear hit the same pending bit in the same cycle, the bit ends up set.
- R6: irq_o is the OR of all interrupt-pending bits; err_irq_o is the OR of each error-pending bit ANDed with its error-interrupt-enable bit.
- R7: With control bit 2 clear, the lowest-numbered channel with periph_req_i high and request enable set is granted; gnt_vld_o and gnt_ch_o show it after the next clock edge.
- R8: With control bit 2 set, the search starts at the channel just above the last one granted and wraps past 31 to 0; after reset the last granted is taken as 31.
- R9: With control bit 5 set, or with control bit 4 set while any error-pending bit is set, gnt_vld_o stays low.
- R10: The control word at 0x00 stores bits 1 to 7, 16 and 17 of a write and reads the other bits as 0.
- R11: After reset all bit vectors and the control word are 0, irq_o, err_irq_o and gnt_vld_o are low.
- R12: A read with re_i high returns the addressed word on rdata_o after the next clock edge and holds it until the next read; unlisted addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write strobe |
| re_i | input | 1 | Register read strobe |
| addr_i | input | 8 | Byte offset of the access |
| wdata_i | input | 32 | Write data; command registers use the low byte |
| rdata_o | output | 32 | Read data, registered |
| periph_req_i | input | 32 | Per-channel peripheral request |
| int_evt_i | input | 32 | Per-channel interrupt event pulse |
| err_evt_i | input | 32 | Per-channel error event pulse |
| irq_o | output | 1 | Combined interrupt line |
| err_irq_o | output | 1 | Combined error interrupt line |
| gnt_vld_o | output | 1 | A channel was granted this cycle |
| gnt_ch_o | output | 5 | Number of the granted channel |

## Verification
Commands and events land on the clock edge where they are presented, so the bit vectors and the two interrupt lines, which are decoded straight from them, are due one edge after the stimulus; read data and grants pass through one more register stage fed by the state before that edge, so they also appear after one edge but reflect the prior state. The bench drives every input on the falling edge, advances its own model on the rising edge from the same inputs and the model's pre-edge state, and compares on the next falling edge, so each comparison lands exactly one edge after its cause.

// File: rtl/chan_ctrl_pkg.sv
package chan_ctrl_pkg;
  localparam logic [7:0] OFS_CTRL    = 8'h00;
  localparam logic [7:0] OFS_REQ_EN  = 8'h0C;
  localparam logic [7:0] OFS_ERR_EN  = 8'h14;
  localparam logic [7:0] OFS_CLR_EEN = 8'h18;
  localparam logic [7:0] OFS_SET_EEN = 8'h19;
  localparam logic [7:0] OFS_CLR_REQ = 8'h1A;
  localparam logic [7:0] OFS_SET_REQ = 8'h1B;
  localparam logic [7:0] OFS_CLR_ERR = 8'h1E;
  localparam logic [7:0] OFS_CLR_INT = 8'h1F;
  localparam logic [7:0] OFS_INT     = 8'h24;
  localparam logic [7:0] OFS_ERR     = 8'h2C;

  localparam int CTRL_RR_BIT   = 2;
  localparam int CTRL_HOE_BIT  = 4;
  localparam int CTRL_HALT_BIT = 5;
  localparam logic [31:0] CTRL_WMASK = 32'h0003_00FE;

  typedef enum logic [2:0] {
    CMD_NONE, CMD_SET_REQ, CMD_CLR_REQ, CMD_SET_EEN, CMD_CLR_EEN, CMD_CLR_INT, CMD_CLR_ERR
  } cmd_e;

  function automatic int unsigned low_idx(input logic [31:0] v);
    int unsigned r;
    r = 0;
    for (int i = 31; i >= 0; i--) if (v[i]) r = i;
    return r;
  endfunction
endpackage

// File: rtl/chan_cmd_decode.sv
module chan_cmd_decode #(
  parameter int NCH    = 32,
  parameter int ADDR_W = 8,
  localparam int CH_W  = $clog2(NCH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        byte_i,
  output logic [NCH-1:0]    set_req_o,
  output logic [NCH-1:0]    clr_req_o,
  output logic [NCH-1:0]    set_een_o,
  output logic [NCH-1:0]    clr_een_o,
  output logic [NCH-1:0]    clr_int_o,
  output logic [NCH-1:0]    clr_err_o
);
  import chan_ctrl_pkg::*;

  cmd_e            cmd;
  logic [CH_W-1:0] idx;
  logic [NCH-1:0]  sel;

  assign idx = byte_i[CH_W-1:0];

  always_comb begin
    cmd = CMD_NONE;
    if (we_i) begin
      if      (addr_i == ADDR_W'(OFS_SET_REQ)) cmd = CMD_SET_REQ;
      else if (addr_i == ADDR_W'(OFS_CLR_REQ)) cmd = CMD_CLR_REQ;
      else if (addr_i == ADDR_W'(OFS_SET_EEN)) cmd = CMD_SET_EEN;
      else if (addr_i == ADDR_W'(OFS_CLR_EEN)) cmd = CMD_CLR_EEN;
      else if (addr_i == ADDR_W'(OFS_CLR_INT)) cmd = CMD_CLR_INT;
      else if (addr_i == ADDR_W'(OFS_CLR_ERR)) cmd = CMD_CLR_ERR;
    end
  end

  for (genvar n = 0; n < NCH; n++) begin : g_sel
    assign sel[n] = (idx == CH_W'(n));
  end

  assign set_req_o = (cmd == CMD_SET_REQ) ? sel : '0;
  assign clr_req_o = (cmd == CMD_CLR_REQ) ? sel : '0;
  assign set_een_o = (cmd == CMD_SET_EEN) ? sel : '0;
  assign clr_een_o = (cmd == CMD_CLR_EEN) ? sel : '0;
  assign clr_int_o = (cmd == CMD_CLR_INT) ? sel : '0;
  assign clr_err_o = (cmd == CMD_CLR_ERR) ? sel : '0;

  // R1
  cmd_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(set_req_o | clr_req_o | set_een_o | clr_een_o | clr_int_o | clr_err_o));
endmodule

// File: rtl/chan_bits.sv
module chan_bits #(
  parameter int NCH = 32
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NCH-1:0] set_i,
  input  logic [NCH-1:0] clr_i,
  output logic [NCH-1:0] bits_o
);
  for (genvar n = 0; n < NCH; n++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       bits_o[n] <= 1'b0;
      else if (set_i[n]) bits_o[n] <= 1'b1;  // set beats clear
      else if (clr_i[n]) bits_o[n] <= 1'b0;
    end
  end

  // R5
  set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i != '0) |=> ((bits_o & $past(set_i)) == $past(set_i)));
  // R3
  clr_takes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((clr_i & ~set_i) != '0) |=> ((bits_o & $past(clr_i & ~set_i)) == '0));
endmodule

// File: rtl/chan_arbiter.sv
module chan_arbiter #(
  parameter int NCH   = 32,
  localparam int CH_W = $clog2(NCH)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NCH-1:0]  elig_i,
  input  logic            rr_en_i,
  input  logic            halt_i,
  output logic            gnt_vld_o,
  output logic [CH_W-1:0] gnt_ch_o
);
  import chan_ctrl_pkg::*;

  logic [CH_W-1:0] last_q;
  logic [NCH-1:0]  hi_mask, hi_elig;
  logic [CH_W-1:0] pick;

  assign hi_mask = {NCH{1'b1}} << (int'(last_q) + 1);
  assign hi_elig = elig_i & hi_mask;

  always_comb begin
    if (rr_en_i && hi_elig != '0) pick = CH_W'(low_idx(32'(hi_elig)));
    else                          pick = CH_W'(low_idx(32'(elig_i)));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gnt_vld_o <= 1'b0;
      gnt_ch_o  <= '0;
      last_q    <= CH_W'(NCH - 1);
    end else if (!halt_i && elig_i != '0) begin
      gnt_vld_o <= 1'b1;
      gnt_ch_o  <= pick;
      last_q    <= pick;
    end else begin
      gnt_vld_o <= 1'b0;
    end
  end

  // R9
  halt_blocks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_i |=> !gnt_vld_o);
  // R7
  fixed_lowest_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rr_en_i && !halt_i && elig_i != '0) |=>
      (gnt_vld_o && (($past(elig_i) & ~({NCH{1'b1}} << gnt_ch_o)) == '0)));
endmodule

// File: rtl/chan_ctrl_bank.sv
module chan_ctrl_bank #(
  parameter int NCH    = 32,
  parameter int ADDR_W = 8,
  localparam int CH_W  = $clog2(NCH),
  localparam int DW    = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              re_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  input  logic [NCH-1:0]    periph_req_i,
  input  logic [NCH-1:0]    int_evt_i,
  input  logic [NCH-1:0]    err_evt_i,
  output logic              irq_o,
  output logic              err_irq_o,
  output logic              gnt_vld_o,
  output logic [CH_W-1:0]   gnt_ch_o
);
  import chan_ctrl_pkg::*;

  logic [NCH-1:0] set_req, clr_req, set_een, clr_een, clr_int, clr_err;
  logic [NCH-1:0] req_en, err_en, int_pend, err_pend;
  logic [DW-1:0]  ctrl_q, rd_d;
  logic           halt;

  chan_cmd_decode #(.NCH(NCH), .ADDR_W(ADDR_W)) u_dec (
    .clk_i, .rst_ni, .we_i, .addr_i, .byte_i(wdata_i[7:0]),
    .set_req_o(set_req), .clr_req_o(clr_req), .set_een_o(set_een),
    .clr_een_o(clr_een), .clr_int_o(clr_int), .clr_err_o(clr_err)
  );

  chan_bits #(.NCH(NCH)) u_req (.clk_i, .rst_ni, .set_i(set_req),   .clr_i(clr_req), .bits_o(req_en));
  chan_bits #(.NCH(NCH)) u_een (.clk_i, .rst_ni, .set_i(set_een),   .clr_i(clr_een), .bits_o(err_en));
  chan_bits #(.NCH(NCH)) u_int (.clk_i, .rst_ni, .set_i(int_evt_i), .clr_i(clr_int), .bits_o(int_pend));
  chan_bits #(.NCH(NCH)) u_err (.clk_i, .rst_ni, .set_i(err_evt_i), .clr_i(clr_err), .bits_o(err_pend));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                    ctrl_q <= '0;
    else if (we_i && addr_i == ADDR_W'(OFS_CTRL))   ctrl_q <= wdata_i & CTRL_WMASK;
  end

  assign halt = ctrl_q[CTRL_HALT_BIT] | (ctrl_q[CTRL_HOE_BIT] & (|err_pend));

  chan_arbiter #(.NCH(NCH)) u_arb (
    .clk_i, .rst_ni, .elig_i(req_en & periph_req_i), .rr_en_i(ctrl_q[CTRL_RR_BIT]),
    .halt_i(halt), .gnt_vld_o, .gnt_ch_o
  );

  assign irq_o     = |int_pend;
  assign err_irq_o = |(err_pend & err_en);

  always_comb begin
    rd_d = '0;
    if      (addr_i == ADDR_W'(OFS_CTRL))   rd_d = ctrl_q;
    else if (addr_i == ADDR_W'(OFS_REQ_EN)) rd_d = DW'(req_en);
    else if (addr_i == ADDR_W'(OFS_ERR_EN)) rd_d = DW'(err_en);
    else if (addr_i == ADDR_W'(OFS_INT))    rd_d = DW'(int_pend);
    else if (addr_i == ADDR_W'(OFS_ERR))    rd_d = DW'(err_pend);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (re_i) rdata_o <= rd_d;
  end

  // R6
  err_line_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_irq_o |-> (err_en != '0));
  // R10
  ctrl_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q & ~CTRL_WMASK) == '0);
endmodule

// File: tb/sim_chan_ctrl_bank.sv
`timescale 1ns/1ps
module sim_chan_ctrl_bank;
  localparam int NCH = 32;

  logic        clk = 1'b0, rst_ni = 1'b0;
  logic        we = 0, re = 0;
  logic [7:0]  addr = 0;
  logic [31:0] wdata = 0, rdata, preq = 0, ievt = 0, eevt = 0;
  logic        irq, err_irq, gv;
  logic [4:0]  gch;

  always #2.5 clk = ~clk;

  chan_ctrl_bank u0 (
    .clk_i(clk), .rst_ni, .we_i(we), .re_i(re), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .periph_req_i(preq), .int_evt_i(ievt), .err_evt_i(eevt),
    .irq_o(irq), .err_irq_o(err_irq), .gnt_vld_o(gv), .gnt_ch_o(gch)
  );

  int n_chk = 0, n_fail = 0;
  logic [31:0] m_req, m_een, m_int, m_err, m_ctrl, m_rd;
  logic [4:0]  m_last, m_gch;
  logic        m_gv, m_halted;
  string       m_rd_tag;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic string tag_of(logic [7:0] a);
    case (a)
      8'h00: return "R10";
      8'h0C: return "R1";
      8'h14: return "R2";
      8'h24: return "R3";
      8'h2C: return "R4";
      default: return "R12";
    endcase
  endfunction

  // reference model, advanced on the same edge as the design
  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_req = 0; m_een = 0; m_int = 0; m_err = 0; m_ctrl = 0; m_rd = 0;
      m_last = 5'd31; m_gch = 0; m_gv = 0; m_halted = 0; m_rd_tag = "R11";
    end else begin
      logic [31:0] elig, n_req, n_een, n_int, n_err, n_ctrl;
      logic [4:0]  c;
      logic        found;
      m_halted = m_ctrl[5] || (m_ctrl[4] && m_err != 0);
      elig = m_req & preq;
      m_gv = 0;
      if (!m_halted && elig != 0) begin
        found = 0;
        if (m_ctrl[2]) begin
          for (int k = 1; k <= NCH; k++) begin
            c = 5'(int'(m_last) + k);
            if (!found && elig[c]) begin found = 1; m_gch = c; end
          end
        end else begin
          for (int k = 0; k < NCH; k++)
            if (!found && elig[k]) begin found = 1; m_gch = 5'(k); end
        end
        m_gv = 1; m_last = m_gch;
      end
      if (re) begin
        m_rd_tag = tag_of(addr);
        case (addr)
          8'h00: m_rd = m_ctrl;
          8'h0C: m_rd = m_req;
          8'h14: m_rd = m_een;
          8'h24: m_rd = m_int;
          8'h2C: m_rd = m_err;
          default: m_rd = 0;
        endcase
      end
      n_req = m_req; n_een = m_een; n_int = m_int; n_err = m_err; n_ctrl = m_ctrl;
      c = wdata[4:0];
      if (we) case (addr)
        8'h1B: n_req[c] = 1;
        8'h1A: n_req[c] = 0;
        8'h19: n_een[c] = 1;
        8'h18: n_een[c] = 0;
        8'h1F: n_int[c] = 0;
        8'h1E: n_err[c] = 0;
        8'h00: n_ctrl = wdata & 32'h0003_00FE;
        default: ;
      endcase
      m_req = n_req; m_een = n_een; m_int = n_int | ievt; m_err = n_err | eevt; m_ctrl = n_ctrl;
    end
  end

  task automatic check_all();
    chk("R6 irq", 32'(irq), 32'(m_int != 0));
    chk("R6 err_irq", 32'(err_irq), 32'((m_err & m_een) != 0));
    chk(m_halted ? "R9 grant valid" : "R7/R8 grant valid", 32'(gv), 32'(m_gv));
    if (m_gv) chk(m_ctrl[2] ? "R8 grant ch" : "R7 grant ch", 32'(gch), 32'(m_gch));
    chk({m_rd_tag, " rdata"}, rdata, m_rd);
  endtask

  task automatic step(bit w, logic [7:0] a, logic [31:0] d, bit r,
                      logic [31:0] pr, logic [31:0] ie, logic [31:0] ee);
    we = w; addr = a; wdata = d; re = r; preq = pr; ievt = ie; eevt = ee;
    @(negedge clk);
    we = 0; re = 0; ievt = 0; eevt = 0;
    check_all();
  endtask

  task automatic rd(logic [7:0] a);
    step(0, a, 0, 1, preq, 0, 0);
  endtask

  function automatic logic [31:0] sparse();
    return (($urandom % 4) == 0) ? (32'd1 << ($urandom % 32)) : 32'd0;
  endfunction

  initial begin
    #(5.0 * 150000);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] cmd_addrs [7];
    logic [7:0] rd_addrs [6];
    void'($urandom(32'd20240611));
    cmd_addrs = '{8'h1B, 8'h1A, 8'h19, 8'h18, 8'h1F, 8'h1E, 8'h00};
    rd_addrs  = '{8'h00, 8'h0C, 8'h14, 8'h24, 8'h2C, 8'h30};
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 irq", 32'(irq), 0);
    chk("R11 err_irq", 32'(err_irq), 0);
    chk("R11 gnt_vld", 32'(gv), 0);
    rst_ni = 1;
    @(negedge clk);
    rd(8'h00); chk("R11 ctrl after reset", rdata, 0);
    rd(8'h24); chk("R11 int pend after reset", rdata, 0);

    // R1 upper bits of command byte ignored: 0xE4 selects channel 4
    step(1, 8'h1B, 32'hE4, 0, 0, 0, 0);
    rd(8'h0C); chk("R1 set via byte 0xE4", rdata, 32'h10);
    step(1, 8'h1A, 32'h04, 0, 0, 0, 0);
    rd(8'h0C); chk("R1 clear ch4", rdata, 0);

    // R5 event and clear on same bit in one cycle
    step(1, 8'h1F, 32'd3, 0, 0, 32'h8, 0);
    rd(8'h24); chk("R5 set beats clear", rdata, 32'h8);
    rd(8'h24); chk("R3 read has no side effect", rdata, 32'h8);
    chk("R3 irq still high", 32'(irq), 1);
    step(1, 8'h1F, 32'd3, 0, 0, 0, 0);
    chk("R3 clear drops irq", 32'(irq), 0);

    // R4 / R2 / R6 error path
    step(0, 0, 0, 0, 0, 0, 32'h0001_0000);
    chk("R6 error not enabled", 32'(err_irq), 0);
    step(1, 8'h19, 32'd16, 0, 0, 0, 0);
    chk("R2 enable raises err_irq", 32'(err_irq), 1);
    step(1, 8'h1E, 32'd16, 0, 0, 0, 0);
    rd(8'h2C); chk("R4 err cleared", rdata, 0);

    // R7 fixed priority, channels 5 and 9
    step(1, 8'h1B, 32'd5, 0, 0, 0, 0);
    step(1, 8'h1B, 32'd9, 0, 0, 0, 0);
    step(0, 0, 0, 0, 32'h0000_0220, 0, 0);
    chk("R7 lowest wins", 32'(gch), 5);
    step(0, 0, 0, 0, 32'h0000_0220, 0, 0);
    chk("R7 lowest again", 32'(gch), 5);
    // R8 round robin alternates
    step(1, 8'h00, 32'h4, 0, 32'h0000_0220, 0, 0);
    step(0, 0, 0, 0, 32'h0000_0220, 0, 0);
    chk("R8 after 5 comes 9", 32'(gch), 9);
    step(0, 0, 0, 0, 32'h0000_0220, 0, 0);
    chk("R8 wraps to 5", 32'(gch), 5);
    // R9 halt
    step(1, 8'h00, 32'h24, 0, 32'h0000_0220, 0, 0);
    step(0, 0, 0, 0, 32'h0000_0220, 0, 0);
    chk("R9 halt blocks", 32'(gv), 0);
    step(1, 8'h00, 32'h14, 0, 32'h0000_0220, 0, 32'h1);
    step(0, 0, 0, 0, 32'h0000_0220, 0, 0);
    chk("R9 halt on error blocks", 32'(gv), 0);
    step(1, 8'h1E, 32'd0, 0, 32'h0000_0220, 0, 0);
    step(0, 0, 0, 0, 32'h0000_0220, 0, 0);
    chk("R9 resumes after clear", 32'(gv), 1);
    // R10 mask
    step(1, 8'h00, 32'hFFFF_FFFF, 0, 0, 0, 0);
    rd(8'h00); chk("R10 writable mask", rdata, 32'h0003_00FE);
    step(1, 8'h00, 32'h0, 0, 0, 0, 0);

    // constrained random
    for (int i = 0; i < 4000; i++) begin
      bit w, r;
      logic [7:0] a, ra;
      logic [31:0] d;
      w = ($urandom % 2) == 0;
      a = cmd_addrs[$urandom % 7];
      d = $urandom;
      if (a == 8'h00) d = (d & ~32'h20) | ((($urandom % 8) == 0) ? 32'h20 : 32'h0);
      r = ($urandom % 2) == 0;
      ra = rd_addrs[$urandom % 6];
      if (r && !w) a = ra;
      else if (r) a = w ? a : ra;
      step(w, a, d, r && (!w || a == ra), $urandom, sparse(), sparse());
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule